// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of an SDRAM read or write burst. A controller pulses `start_i` together with the starting column and the burst-mode field taken from its mode register. From the next clock on, the block presents one column address per clock on `col_o` with `valid_o` high, and marks the final beat of a fixed-length burst with `last_o`.

Lengths of 1, 2, 4 and 8 beats wrap inside an aligned block of that size, using either the sequential or the interleaved wrap order. The full-page length walks the whole 512-column row and wraps at its end. It never finishes by itself, so a stop pulse or a new start must end it. A new start in any cycle abandons the burst in progress, which allows back-to-back column commands on every clock. The data path, the DRAM timing counters and the command encoding live in other blocks.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `valid_o` and `last_o` are 0.
- R2: When `start_i` is sampled high, `valid_o` is 1 in the following cycle and `col_o` equals the `start_col_i` value that was sampled with it.
- R3: Bits 2:0 of `mode_i` select the length: 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, 7 gives full page, and the reserved codes 4, 5 and 6 give 1 beat.
- R4: With `mode_i` bit 3 clear, beat n of a fixed-length burst of length BL has low log2(BL) column bits equal to (start low bits + n) mod BL. The upper bits equal those of the start column.
- R5: With `mode_i` bit 3 set, beat n of a fixed-length burst has low log2(BL) bits equal to the start low bits XOR n. The upper bits are unchanged.
- R6: `last_o` is 1 only on beat BL-1 of a fixed-length burst. When no new start is sampled on that beat, `valid_o` is 0 in the next cycle.
- R7: In full-page mode every beat adds 1 to the whole column modulo 512, `mode_i` bit 3 is ignored, and `last_o` stays 0 for any number of beats.
- R8: When `stop_i` is sampled high during a burst with no start, `valid_o` is 0 in the next cycle. `stop_i` has no effect while idle.
- R9: A start sampled during a burst, or together with `stop_i`, begins the new burst at beat 0 in the next cycle.
- R10: Changes on `mode_i` and `start_col_i` after the start cycle do not alter the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst this cycle |
| start_col_i | input | 9 | Starting column of the burst |
| mode_i | input | 4 | Bits 2:0 length code, bit 3 interleaved order |
| stop_i | input | 1 | Terminate the current burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
Every result lands exactly one clock after the edge that samples its cause. Beat 0 appears one edge after the start, each later beat comes one edge after the previous one, and `valid_o` falls one edge after a stop or after the last beat. The bench drives its inputs on falling edges and reads the outputs on the next falling edge. Each read therefore shows the state that the one rising edge in between produced. Expected columns come from a modular-arithmetic model of the two wrap orders, and that model is computed separately for every beat.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
   localparam int MODE_W     = 4;
   localparam int LG_W       = 2;
   localparam int MAX_LG     = 3;

   // decoded burst configuration, latched at start
   typedef struct packed {
      logic            full;
      logic            ilv;
      logic [LG_W-1:0] lg;
   } burst_cfg_t;

   localparam logic [2:0] LEN_FULL_CODE = 3'd7;
endpackage

// File: rtl/bcg_mode_decode.sv
module bcg_mode_decode
   import bcg_pkg::*;
#(
   parameter int MW = MODE_W
) (
   input  logic [MW-1:0] mode,
   output burst_cfg_t    cfg
);
   generate
      if (MW < 4) begin : g_bad_mw
         $error("bcg_mode_decode: mode field needs at least 4 bits");
      end
   endgenerate

   logic [2:0] len_code;
   assign len_code = mode[2:0];

   always_comb begin
      cfg.ilv  = mode[3];
      cfg.full = 1'b0;
      cfg.lg   = '0;
      if (len_code == LEN_FULL_CODE) begin
         cfg.full = 1'b1;
      end else if (len_code <= 3'(MAX_LG)) begin
         cfg.lg = len_code[LG_W-1:0];
      end
      // reserved codes keep lg = 0, i.e. a single beat
   end
endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl
   import bcg_pkg::*;
#(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          stop,
   input  burst_cfg_t    cfg_in,
   output logic          active,
   output logic [CW-1:0] beat,
   output burst_cfg_t    cfg_q,
   output logic          last
);
   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] len_m1;
   assign len_m1 = (ONE << cfg_q.lg) - ONE;
   assign last   = active && !cfg_q.full && (beat == len_m1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         beat   <= '0;
         cfg_q  <= '0;
      end else if (start) begin
         active <= 1'b1;
         beat   <= '0;
         cfg_q  <= cfg_in;
      end else if (active && (stop || last)) begin
         active <= 1'b0;
         beat   <= '0;
      end else if (active) begin
         beat   <= beat + ONE;
      end
   end
endmodule

// File: rtl/bcg_col_order.sv
module bcg_col_order
   import bcg_pkg::*;
#(
   parameter int CW      = 9,
   parameter bit HAS_ILV = 1'b1
) (
   input  logic [CW-1:0] base_col,
   input  logic [CW-1:0] beat,
   input  burst_cfg_t    cfg,
   output logic [CW-1:0] col
);
   logic [CW-1:0] wrap_mask;
   logic [CW-1:0] seq_col;
   logic [CW-1:0] sum;

   // one mask bit per column bit: inside the wrap block or not
   generate
      for (genvar b = 0; b < CW; b++) begin : g_mask
         if (b < MAX_LG) begin : g_low
            assign wrap_mask[b] = cfg.full || (int'(cfg.lg) > b);
         end else begin : g_high
            assign wrap_mask[b] = cfg.full;
         end
      end
   endgenerate

   assign sum     = base_col + beat;
   assign seq_col = (base_col & ~wrap_mask) | (sum & wrap_mask);

   generate
      if (HAS_ILV) begin : g_ilv
         logic [CW-1:0] ilv_col;
         assign ilv_col = (base_col & ~wrap_mask) | ((base_col ^ beat) & wrap_mask);
         assign col     = (cfg.ilv && !cfg.full) ? ilv_col : seq_col;
      end else begin : g_seq_only
         assign col = seq_col;
      end
   endgenerate
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import bcg_pkg::*;
#(
   parameter int COL_W   = 9,
   parameter bit HAS_ILV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [3:0]       mode_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);
   generate
      if (COL_W <= MAX_LG) begin : g_bad_cw
         $error("burst_col_gen: column width must exceed the largest wrap block");
      end
   endgenerate

   burst_cfg_t       cfg_dec;
   burst_cfg_t       cfg_q;
   logic             active;
   logic [COL_W-1:0] beat;
   logic [COL_W-1:0] base_q;
   logic             last;

   bcg_mode_decode #(.MW(4)) u_dec (
      .mode (mode_i),
      .cfg  (cfg_dec)
   );

   bcg_beat_ctrl #(.CW(COL_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_i),
      .stop   (stop_i),
      .cfg_in (cfg_dec),
      .active (active),
      .beat   (beat),
      .cfg_q  (cfg_q),
      .last   (last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       base_q <= '0;
      else if (start_i) base_q <= start_col_i;
   end

   bcg_col_order #(.CW(COL_W), .HAS_ILV(HAS_ILV)) u_order (
      .base_col (base_q),
      .beat     (beat),
      .cfg      (cfg_q),
      .col      (col_o)
   );

   assign valid_o = active;
   assign last_o  = last;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
   parameter int COL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic             stop_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o
);
   // R2
   start_beat0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && col_o == $past(start_col_i)));

   // R6
   last_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   // R6
   last_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !valid_o);

   // R8
   stop_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && stop_i && !start_i) |=> !valid_o);

   // R4
   burst_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o && !stop_i && !start_i) |=> valid_o);

   // R1
   idle_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> !last_o);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .start_col_i (start_col_i),
   .stop_i      (stop_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o)
);

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CW         = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [CW-1:0] start_col_i = '0;
   logic [3:0]    mode_i = '0;
   logic          stop_i = 1'b0;
   logic [CW-1:0] col_o;
   logic          valid_o;
   logic          last_o;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_col_gen dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .mode_i(mode_i), .stop_i(stop_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int blen(input logic [3:0] m);
      case (m[2:0])
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 8;
         3'd7: return 0; // full page
         default: return 1;
      endcase
   endfunction

   function automatic int exp_col(input int st, input int n, input logic [3:0] m);
      int bl = blen(m);
      int base, off;
      if (bl == 0) return (st + n) % 512;
      base = st - (st % bl);
      off  = st % bl;
      if (m[3]) return base + (off ^ (n % bl));
      return base + ((off + n) % bl);
   endfunction

   // at a falling edge: issue start, then advance to the next falling edge (beat 0 visible)
   task automatic launch(input int col, input logic [3:0] m);
      start_i = 1'b1; start_col_i = CW'(col); mode_i = m;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic check_beat(input string tag, input int st, input int n, input logic [3:0] m);
      int bl = blen(m);
      bit exp_last = (bl != 0) && (n == bl - 1);
      check(valid_o === 1'b1, {tag, " valid"}, int'(valid_o), 1);
      check(col_o === CW'(exp_col(st, n, m)), {tag, " col"}, int'(col_o), exp_col(st, n, m));
      check(last_o === exp_last, {tag, " last"}, int'(last_o), int'(exp_last));
   endtask

   task automatic full_burst(input string tag, input int st, input logic [3:0] m);
      int bl = blen(m);
      launch(st, m);
      for (int n = 0; n < bl; n++) begin
         check_beat(tag, st, n, m);
         @(negedge clk);
      end
      check(valid_o === 1'b0, {tag, " ends R6"}, int'(valid_o), 0);
   endtask

   task automatic t_reset();
      check(valid_o === 1'b0, "R1 valid in reset", int'(valid_o), 0);
      check(last_o === 1'b0, "R1 last in reset", int'(last_o), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check(valid_o === 1'b0, "R1 valid after reset", int'(valid_o), 0);
      check(last_o === 1'b0, "R1 last after reset", int'(last_o), 0);
   endtask

   task automatic t_lengths();
      full_burst("R3 R2 len1", 9'h0A5, 4'b0000);
      full_burst("R3 len2", 9'h033, 4'b0001);
      full_burst("R3 R4 seq4", 9'h0E6, 4'b0010);
      full_burst("R4 seq8", 9'h15D, 4'b0011);
      full_burst("R3 reserved5", 9'h101, 4'b0101);
      full_burst("R3 reserved6", 9'h1C2, 4'b1110);
   endtask

   task automatic t_interleave();
      full_burst("R5 ilv8", 9'h1F5, 4'b1011);
      full_burst("R5 ilv4", 9'h07B, 4'b1010);
      full_burst("R5 ilv2", 9'h0C1, 4'b1001);
   endtask

   task automatic t_full_page();
      launch(9'h1FE, 4'b1111);
      for (int n = 0; n < 530; n++) begin
         check_beat("R7 full page", 9'h1FE, n, 4'b1111);
         if (n == 529) stop_i = 1'b1;
         @(negedge clk);
      end
      stop_i = 1'b0;
      check(valid_o === 1'b0, "R8 stop full page", int'(valid_o), 0);
   endtask

   task automatic t_stop();
      launch(9'h020, 4'b0011);
      check_beat("R8 pre-stop", 9'h020, 0, 4'b0011);
      @(negedge clk);
      check_beat("R8 pre-stop", 9'h020, 1, 4'b0011);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      check(valid_o === 1'b0, "R8 stop mid burst", int'(valid_o), 0);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      check(valid_o === 1'b0, "R8 stop idle", int'(valid_o), 0);
      full_burst("R8 burst after idle stop", 9'h044, 4'b0010);
   endtask

   task automatic t_restart();
      launch(9'h010, 4'b0011);
      check_beat("R9 first", 9'h010, 0, 4'b0011);
      @(negedge clk);
      check_beat("R9 first", 9'h010, 1, 4'b0011);
      stop_i = 1'b1;
      launch(9'h0A3, 4'b1010);
      stop_i = 1'b0;
      for (int n = 0; n < 4; n++) begin
         check_beat("R9 restart", 9'h0A3, n, 4'b1010);
         // back-to-back start on the final beat
         if (n == 3) launch(9'h1B0, 4'b0001);
         else @(negedge clk);
      end
      check_beat("R9 back-to-back", 9'h1B0, 0, 4'b0001);
      @(negedge clk);
      check_beat("R9 back-to-back", 9'h1B0, 1, 4'b0001);
      @(negedge clk);
      check(valid_o === 1'b0, "R9 end", int'(valid_o), 0);
   endtask

   task automatic t_mode_hold();
      launch(9'h0E6, 4'b0010);
      for (int n = 0; n < 4; n++) begin
         mode_i = 4'b1111; start_col_i = 9'h155;
         check_beat("R10 mode held", 9'h0E6, n, 4'b0010);
         @(negedge clk);
      end
      check(valid_o === 1'b0, "R10 end", int'(valid_o), 0);
   endtask

   initial begin
      fork
         begin
            @(negedge clk);
            t_reset();
            t_lengths();
            t_interleave();
            t_stop();
            t_restart();
            t_mode_hold();
            t_full_page();
         end
         begin
            repeat (20000) @(posedge clk);
            failures++;
            checks++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule